// File: doc/BRIEF.md
# Priority Interrupt Controller with Break Input

This block gathers the maskable request lines of a chip's on-chip peripherals and turns them into one external-interrupt request for the CPU. There are 32 request lines. Each line stands for a group of peripheral causes, and it stays high until the peripheral drops it. Software gives every line a 3-bit urgency level. Level 0 is the most urgent. Level 7 switches the line off. Among the enabled lines that are raised, the controller finds the most urgent one. A tie on the level goes to the lowest line number. The interrupt output rises only when the winner's level is numerically below a mask level that the CPU programs.

When the CPU accepts a maskable interrupt, it pulses an acknowledge. The controller then pushes the current mask onto a small stack and raises the mask to the accepted level. A restore strobe pops the stack, so handlers can nest. A separate break pin, active low, passes through a two-flop synchronizer. Its falling edge sets a sticky break flag. The mask and the CPU's interrupt-enable state never gate this flag, and only a break acknowledge clears it. Software reaches the priority, mask and vector registers through a plain single-cycle write port and a combinational read port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every source level reads 7, the mask level reads 7, the vector reads 0, and both `extIrq` and `brkIrq` are low.
- R2: A source whose level is 7 never wins arbitration and never raises `extIrq`, even while its request is high.
- R3: Among the raised and enabled sources, the one with the numerically smallest level wins.
- R4: When raised sources share the smallest level, the one with the lowest index wins.
- R5: `extIrq` is high exactly when a winner exists and its level is strictly less than the mask level, which is bits 2:0 at address 4.
- R6: Address 5 reads the vector: bit 31 is the valid flag, bits 10:8 hold the winner's level, bits 4:0 hold its index, and every other bit is zero.
- R7: A high-to-low transition on `brkN` sets `brkIrq` on the third rising clock edge after the change. The flag stays set while the pin is held, and a held-low pin does not set it again.
- R8: `brkIrq` is set regardless of the mask level and of `extIrq`.
- R9: A `brkAck` pulse clears `brkIrq` on the next clock edge.
- R10: A `cpuAck` pulse while `extIrq` is high pushes the mask onto a stack (depth 4) and loads the winner's level as the new mask. `maskRestore` pops the saved value back. A restore on an empty stack leaves the mask unchanged. A `cpuAck` while `extIrq` is low is ignored.
- R11: Requests are level-sensitive: dropping a request line removes it from arbitration in the same cycle.
- R12: Addresses 0 to 3 hold the levels. Source n sits at address n/8, bits 4*(n%8)+2 down to 4*(n%8). The fourth bit of each nibble reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqReq | input | 32 | Level-sensitive maskable request lines |
| brkN | input | 1 | Asynchronous break pin, falling edge active |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for both write and read |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` |
| cpuAck | input | 1 | CPU accepts the current maskable interrupt |
| maskRestore | input | 1 | Pops the saved mask level |
| brkAck | input | 1 | Clears the break flag |
| extIrq | output | 1 | External-interrupt request to the CPU |
| brkIrq | output | 1 | Sticky break request to the CPU |

## Verification
The bench sets up level ties between a low and a high index. A design with a non-strict compare would hand the tie to the higher index. It also tests a winner whose level equals the mask, where an off-by-one compare would raise `extIrq` wrongly. It holds the break pin low across an acknowledge and counts the exact edge on which the flag appears. An edge detector that works on the level, or that has the wrong number of stages, shows up as a retrigger or a one-cycle shift. Nested acknowledges, a restore on an empty stack, and an acknowledge with nothing eligible catch a stack that loses order, underflows, or pushes when it should not.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic pushMask;   // accepted interrupt: save mask, raise to winner level
    logic popMask;    // restore previously saved mask
    logic wrMask;     // software write of mask level
    logic wrPrio;     // software write of a level word
  } picStrobe_t;

  function automatic int ptrWidth(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int LVL_W   = 3,
  parameter int ID_W    = 5
) (
  input  logic [NUM_SRC-1:0]       reqVec,
  input  logic [NUM_SRC*LVL_W-1:0] lvlFlat,
  output logic                     winValid,
  output logic [LVL_W-1:0]         winLvl,
  output logic [ID_W-1:0]          winId
);

  localparam logic [LVL_W-1:0] DIS_LVL = {LVL_W{1'b1}};

  // Linear scan from index 0 upward; strict compare keeps the lower index
  // on a tie, which gives the fixed hardware order.
  always_comb begin
    winValid = 1'b0;
    winLvl   = DIS_LVL;
    winId    = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reqVec[i] && (lvlFlat[i*LVL_W +: LVL_W] != DIS_LVL) &&
          (lvlFlat[i*LVL_W +: LVL_W] < winLvl)) begin
        winValid = 1'b1;
        winLvl   = lvlFlat[i*LVL_W +: LVL_W];
        winId    = ID_W'(i);
      end
    end
  end

endmodule

// File: rtl/pic_control.sv
module pic_control
  import prio_irq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int PRIO_WORDS = 4,
  parameter int MASK_ADDR  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              brkN,
  input  logic              brkAck,
  input  logic              cpuAck,
  input  logic              maskRestore,
  input  logic              extIrq,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output picStrobe_t        strobe,
  output logic              brkIrq,
  output logic              brkFall
);

  logic syncA, syncB, brkPrev, brkPend;

  // Two-flop synchronizer plus one history flop for edge detection.
  // Idle level of the pin is high, so reset loads ones: no false edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b1;
      syncB   <= 1'b1;
      brkPrev <= 1'b1;
    end else begin
      syncA   <= brkN;
      syncB   <= syncA;
      brkPrev <= syncB;
    end
  end

  assign brkFall = brkPrev & ~syncB;

  // Sticky flag; a new edge in the same cycle as the acknowledge wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        brkPend <= 1'b0;
    else if (brkFall) brkPend <= 1'b1;
    else if (brkAck)  brkPend <= 1'b0;
  end

  assign brkIrq = brkPend;

  // Acknowledge of an eligible interrupt outranks restore, which outranks
  // a software write of the mask.
  always_comb begin
    strobe.pushMask = cpuAck & extIrq;
    strobe.popMask  = maskRestore & ~strobe.pushMask;
    strobe.wrMask   = regWe && (regAddr == ADDR_W'(MASK_ADDR));
    strobe.wrPrio   = regWe && (regAddr < ADDR_W'(PRIO_WORDS));
  end

endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int LVL_W       = 3,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int STACK_DEPTH = 4,
  parameter int FIELD_W     = 4,
  parameter int PRIO_WORDS  = 4,
  parameter int MASK_ADDR   = 4,
  parameter int VEC_ADDR    = 5,
  parameter int ID_W        = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  picStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               extIrq,
  output logic               winValid,
  output logic [LVL_W-1:0]   winLvl,
  output logic [ID_W-1:0]    winId,
  output logic [LVL_W-1:0]   maskLvl
);

  localparam int PER_WORD = DATA_W / FIELD_W;
  localparam int PTR_W    = ptrWidth(STACK_DEPTH);
  localparam int CNT_W    = $clog2(STACK_DEPTH + 1);
  localparam int WIDX_W   = ptrWidth(PRIO_WORDS);
  localparam logic [LVL_W-1:0] DIS_LVL = {LVL_W{1'b1}};

  logic [NUM_SRC*LVL_W-1:0] lvlFlat;
  logic [DATA_W-1:0]        prioWord [PRIO_WORDS];

  // ---------------- level registers, one per source ----------------
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int WORD = s / PER_WORD;
    localparam int SLOT = s % PER_WORD;
    logic [LVL_W-1:0] lvlReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lvlReg <= DIS_LVL;
      else if (strobe.wrPrio && (regAddr == ADDR_W'(WORD)))
        lvlReg <= regWdata[SLOT*FIELD_W +: LVL_W];
    end

    assign lvlFlat[s*LVL_W +: LVL_W] = lvlReg;
  end

  // ---------------- read view of the level words ----------------
  for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_word
    always_comb begin
      prioWord[w] = '0;
      for (int j = 0; j < PER_WORD; j++)
        prioWord[w][j*FIELD_W +: LVL_W] = lvlFlat[(w*PER_WORD + j)*LVL_W +: LVL_W];
    end
  end

  // ---------------- arbitration ----------------
  pic_arbiter #(
    .NUM_SRC (NUM_SRC),
    .LVL_W   (LVL_W),
    .ID_W    (ID_W)
  ) u_arb (
    .reqVec   (irqReq),
    .lvlFlat  (lvlFlat),
    .winValid (winValid),
    .winLvl   (winLvl),
    .winId    (winId)
  );

  assign extIrq = winValid && (winLvl < maskLvl);

  // ---------------- mask level with save stack ----------------
  logic [LVL_W-1:0] stackMem [STACK_DEPTH];
  logic [CNT_W-1:0] depth;
  logic [CNT_W-1:0] depthM1;
  logic             stackFull, stackEmpty;

  assign depthM1    = depth - CNT_W'(1);
  assign stackFull  = (depth == CNT_W'(STACK_DEPTH));
  assign stackEmpty = (depth == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskLvl <= DIS_LVL;
      depth   <= '0;
      for (int k = 0; k < STACK_DEPTH; k++) stackMem[k] <= '0;
    end else if (strobe.pushMask) begin
      maskLvl <= winLvl;
      if (!stackFull) begin
        stackMem[depth[PTR_W-1:0]] <= maskLvl;
        depth <= depth + CNT_W'(1);
      end
    end else if (strobe.popMask) begin
      if (!stackEmpty) begin
        maskLvl <= stackMem[depthM1[PTR_W-1:0]];
        depth   <= depthM1;
      end
    end else if (strobe.wrMask) begin
      maskLvl <= regWdata[LVL_W-1:0];
    end
  end

  // ---------------- read mux ----------------
  logic [DATA_W-1:0] vecWord;

  always_comb begin
    vecWord = '0;
    vecWord[DATA_W-1]     = winValid;
    vecWord[8 +: LVL_W]   = winValid ? winLvl : '0;
    vecWord[0 +: ID_W]    = winValid ? winId  : '0;
  end

  always_comb begin
    if (regAddr < ADDR_W'(PRIO_WORDS))
      regRdata = prioWord[regAddr[WIDX_W-1:0]];
    else if (regAddr == ADDR_W'(MASK_ADDR))
      regRdata = DATA_W'(maskLvl);
    else if (regAddr == ADDR_W'(VEC_ADDR))
      regRdata = vecWord;
    else
      regRdata = '0;
  end

  // Write-data bits that no field uses.
  logic unusedWdata;
  assign unusedWdata = ^regWdata;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int LVL_W       = 3,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int STACK_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               brkN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic               cpuAck,
  input  logic               maskRestore,
  input  logic               brkAck,
  output logic               extIrq,
  output logic               brkIrq
);

  localparam int FIELD_W    = 4;
  localparam int PER_WORD   = DATA_W / FIELD_W;
  localparam int PRIO_WORDS = (NUM_SRC + PER_WORD - 1) / PER_WORD;
  localparam int MASK_ADDR  = PRIO_WORDS;
  localparam int VEC_ADDR   = PRIO_WORDS + 1;
  localparam int ID_W       = ptrWidth(NUM_SRC);

  picStrobe_t       strobe;
  logic             brkFall;
  logic             winValid;
  logic [LVL_W-1:0] winLvl;
  logic [ID_W-1:0]  winId;
  logic [LVL_W-1:0] maskLvl;

  pic_control #(
    .ADDR_W     (ADDR_W),
    .PRIO_WORDS (PRIO_WORDS),
    .MASK_ADDR  (MASK_ADDR)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .brkN        (brkN),
    .brkAck      (brkAck),
    .cpuAck      (cpuAck),
    .maskRestore (maskRestore),
    .extIrq      (extIrq),
    .regWe       (regWe),
    .regAddr     (regAddr),
    .strobe      (strobe),
    .brkIrq      (brkIrq),
    .brkFall     (brkFall)
  );

  pic_datapath #(
    .NUM_SRC     (NUM_SRC),
    .LVL_W       (LVL_W),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .STACK_DEPTH (STACK_DEPTH),
    .FIELD_W     (FIELD_W),
    .PRIO_WORDS  (PRIO_WORDS),
    .MASK_ADDR   (MASK_ADDR),
    .VEC_ADDR    (VEC_ADDR),
    .ID_W        (ID_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .irqReq   (irqReq),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .extIrq   (extIrq),
    .winValid (winValid),
    .winLvl   (winLvl),
    .winId    (winId),
    .maskLvl  (maskLvl)
  );

endmodule

// File: rtl/prio_irq_checker.sv
module prio_irq_checker #(
  parameter int NUM_SRC = 32,
  parameter int LVL_W   = 3,
  parameter int ID_W    = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqReq,
  input logic               extIrq,
  input logic               brkIrq,
  input logic               brkAck,
  input logic               brkFall,
  input logic               cpuAck,
  input logic               winValid,
  input logic [LVL_W-1:0]   winLvl,
  input logic [ID_W-1:0]    winId,
  input logic [LVL_W-1:0]   maskLvl
);

  localparam logic [LVL_W-1:0] DIS_LVL = {LVL_W{1'b1}};

  assert_disabled_never_wins_R2: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (winLvl != DIS_LVL));

  assert_zero_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (maskLvl == '0) |-> !extIrq);

  assert_winner_is_requesting_R11: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> irqReq[winId]);

  assert_break_from_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(brkIrq) |-> $past(brkFall));

  assert_break_ack_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (brkAck && !brkFall) |=> !brkIrq);

  assert_ack_raises_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAck && extIrq) |=> (maskLvl == $past(winLvl)));

endmodule

bind prio_irq_ctrl prio_irq_checker #(
  .NUM_SRC (NUM_SRC),
  .LVL_W   (LVL_W),
  .ID_W    (ID_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irqReq   (irqReq),
  .extIrq   (extIrq),
  .brkIrq   (brkIrq),
  .brkAck   (brkAck),
  .brkFall  (brkFall),
  .cpuAck   (cpuAck),
  .winValid (winValid),
  .winLvl   (winLvl),
  .winId    (winId),
  .maskLvl  (maskLvl)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 32;

  localparam int K_RD  = 0;
  localparam int K_EXT = 1;
  localparam int K_BRK = 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] irqReq = '0;
  logic            brkN = 1'b1;
  logic            regWe = 1'b0;
  logic [3:0]      regAddr = '0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic            cpuAck = 1'b0;
  logic            maskRestore = 1'b0;
  logic            brkAck = 1'b0;
  logic            extIrq;
  logic            brkIrq;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk (clk), .rstN (rstN), .irqReq (irqReq), .brkN (brkN),
    .regWe (regWe), .regAddr (regAddr), .regWdata (regWdata),
    .regRdata (regRdata), .cpuAck (cpuAck), .maskRestore (maskRestore),
    .brkAck (brkAck), .extIrq (extIrq), .brkIrq (brkIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  int    lvlShadow [NSRC];

  // Monitor: at each falling edge, compare every queued expectation.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RD:    act = regRdata;
          K_EXT:   act = {31'b0, extIrq};
          default: act = {31'b0, brkIrq};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
        end
      end
    end
  end

  // Driver-side helpers
  task automatic expectItem(int kind, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    tick(1);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    regAddr = a;
    expectItem(K_RD, exp, req);
  endtask

  function automatic logic [31:0] wordOf(int w);
    logic [31:0] v = '0;
    for (int j = 0; j < 8; j++) v[j*4 +: 3] = 3'(lvlShadow[w*8 + j]);
    return v;
  endfunction

  task automatic setLvl(int src, int lvl);
    lvlShadow[src] = lvl;
    wr(4'(src / 8), wordOf(src / 8));
  endtask

  // Reference arbitration from the requirements.
  function automatic logic [31:0] expVec();
    int best = 7;
    int id = 0;
    for (int i = 0; i < NSRC; i++)
      if (irqReq[i] && lvlShadow[i] != 7 && lvlShadow[i] < best) begin
        best = lvlShadow[i]; id = i;
      end
    if (best == 7) return 32'h0;
    return (32'h1 << 31) | (32'(best) << 8) | 32'(id);
  endfunction

  task automatic pulseAck();
    cpuAck = 1'b1; tick(1); cpuAck = 1'b0;
  endtask

  task automatic pulseRestore();
    maskRestore = 1'b1; tick(1); maskRestore = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NSRC; i++) lvlShadow[i] = 7;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    expectItem(K_EXT, 0, "R1 extIrq after reset");
    expectItem(K_BRK, 0, "R1 brkIrq after reset");
    rd(4, 7, "R1 mask after reset");
    rd(5, 0, "R1 vector after reset");
    for (int w = 0; w < 4; w++) rd(4'(w), 32'h7777_7777 & 32'h7777_7777, "R1 level word after reset");

    // R2 disabled source ignored
    irqReq[5] = 1'b1;
    expectItem(K_EXT, 0, "R2 disabled source raises nothing");
    rd(5, 0, "R2 disabled source not in vector");

    // R3/R6 single enabled source
    setLvl(5, 3);
    expectItem(K_EXT, 1, "R5 level 3 below mask 7");
    rd(5, expVec(), "R6 vector single source");
    rd(5, 32'h8000_0305, "R6 vector literal layout");

    // R3 more urgent source wins
    setLvl(20, 1); irqReq[20] = 1'b1;
    rd(5, expVec(), "R3 lower level wins");

    // R4 tie goes to lower index
    setLvl(9, 1); irqReq[9] = 1'b1;
    rd(5, 32'h8000_0109, "R4 tie lowest index");

    // R12 word layout
    rd(0, wordOf(0), "R12 word 0 layout");
    rd(1, wordOf(1), "R12 word 1 layout");
    rd(2, wordOf(2), "R12 word 2 layout");

    // R5 mask boundary
    wr(4, 1);
    expectItem(K_EXT, 0, "R5 level equal to mask blocked");
    wr(4, 2);
    expectItem(K_EXT, 1, "R5 level below mask passes");

    // R11 dropping a request
    irqReq[9] = 1'b0;
    rd(5, 32'h8000_0114, "R11 dropped request leaves arbitration");
    irqReq[20] = 1'b0;
    rd(5, 32'h8000_0305, "R11 next pending takes over");

    // R10 nested acknowledge and restore
    wr(4, 7);
    pulseAck();
    rd(4, 3, "R10 ack raises mask to level 3");
    expectItem(K_EXT, 0, "R10 same level blocked after ack");
    irqReq[20] = 1'b1;
    expectItem(K_EXT, 1, "R10 more urgent source nests");
    pulseAck();
    rd(4, 1, "R10 second ack mask 1");
    pulseRestore();
    rd(4, 3, "R10 first restore");
    pulseRestore();
    rd(4, 7, "R10 second restore");
    pulseRestore();
    rd(4, 7, "R10 restore on empty stack");
    wr(4, 0);
    expectItem(K_EXT, 0, "R5 mask zero blocks all");
    pulseAck();
    rd(4, 0, "R10 ack ignored while extIrq low");

    // R7/R8 break edge timing, mask fully blocking
    brkN = 1'b0;
    tick(2);
    expectItem(K_BRK, 0, "R7 break not yet after two edges");
    tick(1);
    expectItem(K_BRK, 1, "R7 break set on third edge");
    expectItem(K_EXT, 0, "R8 extIrq unaffected by break");

    // R9 acknowledge clears; held-low pin does not retrigger
    brkAck = 1'b1; tick(1); brkAck = 1'b0;
    expectItem(K_BRK, 0, "R9 break ack clears");
    tick(6);
    expectItem(K_BRK, 0, "R7 held-low pin no retrigger");

    // R8 second edge with all sources disabled
    irqReq = '0;
    brkN = 1'b1; tick(4);
    brkN = 1'b0; tick(3);
    expectItem(K_BRK, 1, "R8 break with nothing pending");

    tick(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule